// File: doc/BRIEF.md
# Digital Low-IF Pulse-Shaping Modulator

This block turns a stream of constellation points, each given as an in-phase and a quadrature amplitude index, into one real-valued sample stream centred on a low intermediate frequency. That stream needs only a single D/A converter. Pulse shaping uses a root-Nyquist response with roll-off 0.4 truncated to four symbol periods. The response is never computed with multipliers. Small read-only tables hold, for each symbol age, each rate and each sample phase, the filter tap already scaled by every possible amplitude. Each sample is the sum of one table read per held symbol.

The output sample clock is fixed. The sample rate is four times the IF, so the step from baseband to IF reduces to picking the I or Q sum and negating every second one of each. The number of samples per symbol can be 4, 8 or 16. A lower symbol rate therefore leaves the IF and the output sample rate where they were. At 4 samples per symbol the IF equals the symbol rate.

A symbol source sees a ready pulse once per symbol period. If it has nothing to offer in that slot, a zero-amplitude symbol takes its place, so the output never stops.

Top module: `lowif_modulator`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `samp_valid` and `sym_ready` are 0 and `samp_out` is 0.
- R2: From the second clock after reset release, `samp_valid` is 1 on every cycle. Each sample reflects the symbol history, sample phase and rotation slot that the block held two clocks earlier.
- R3: `sym_ready` is 1 only in the last sample slot of each symbol period. A symbol is taken only when `sym_valid` is 1 in that slot. `sym_valid`, `sym_i` and `sym_q` in any other cycle have no effect on the output.
- R4: When `sym_valid` is 0 in a ready slot, a zero-amplitude symbol enters the history, and the samples remain continuous.
- R5: Successive samples carry I, Q, −I, −Q and then repeat. Every symbol period starts on the I slot, so the IF is one quarter of the sample rate.
- R6: An index k on `sym_i` or `sym_q` means amplitude 2k−3 (0→−3, 1→−1, 2→+1, 3→+3). Each path's value is the sum over the four most recent symbols of amplitude times the tap for that symbol's age and the current sample phase.
- R7: For a lone +1 symbol, the tap is exactly CSCALE (400) at age 2, phase 0. No tap is larger in magnitude. Taps at age 1 phase q and age 2 phase (N−q) are equal, where N is the samples per symbol.
- R8: `osr_sel` code 0 selects 4, code 1 selects 8, and codes 2 and 3 select 16 samples per symbol. The code is taken only in the last slot of a symbol period, and its value in other cycles is ignored.
- R9: After a rate change, the next symbol period starts at phase 0 with the new length. The new rate's taps apply to every symbol still held in the history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| osr_sel | input | 2 | Samples-per-symbol code, taken at the symbol boundary |
| sym_valid | input | 1 | A symbol is offered |
| sym_i | input | 2 | In-phase amplitude index |
| sym_q | input | 2 | Quadrature amplitude index |
| sym_ready | output | 1 | Last sample slot of the current symbol; symbol taken on this cycle |
| samp_valid | output | 1 | `samp_out` carries a sample |
| samp_out | output | 12 | Two's complement IF sample |

## Verification
The hardest case to reach from the ports is a rate change while non-zero symbols from the old rate are still in the four-deep history. In that case taps of the new rate weight symbols that were accepted at the old one. The stimulus first measures the tap set for each rate separately, by sending a lone +1/+1 symbol between runs of idle slots. It then switches `osr_sel` at random at symbol boundaries in the middle of dense random traffic. It also toggles `osr_sel` and `sym_valid` in the middle of symbols. The bench's scoreboard model sums amplitude times the measured taps and predicts each sample, including the ones that straddle a switch.

// File: rtl/lowif_pkg.sv
package lowif_pkg;

  localparam real PI_R = 3.14159265358979;

  // samples per symbol for a rate code, doubling per step, capped by phase width
  function automatic int osr_len(input int code, input int phw);
    int n;
    n = 4;
    for (int i = 0; i < code; i++) begin
      if (n < (1 << phw)) n = n * 2;
    end
    return n;
  endfunction

  // history entry = {nonzero flag, index}; amplitude 2*idx - (2^idxw - 1)
  function automatic int sym_level(input int code, input int idxw);
    int idx;
    idx = code & ((1 << idxw) - 1);
    if (((code >> idxw) & 1) == 0) return 0;
    return 2 * idx - ((1 << idxw) - 1);
  endfunction

  // root-raised-cosine impulse response, t in symbol periods
  function automatic real rrc(input real t, input real a);
    real x;
    if (t > -1.0e-9 && t < 1.0e-9) return 1.0 - a + 4.0 * a / PI_R;
    x = 4.0 * a * t;
    if ((1.0 - x * x) < 1.0e-6 && (1.0 - x * x) > -1.0e-6)
      return a / $sqrt(2.0) * ((1.0 + 2.0 / PI_R) * $sin(PI_R / (4.0 * a)) +
                               (1.0 - 2.0 / PI_R) * $cos(PI_R / (4.0 * a)));
    return ($sin(PI_R * t * (1.0 - a)) + x * $cos(PI_R * t * (1.0 + a))) /
           (PI_R * t * (1.0 - x * x));
  endfunction

  function automatic int round_int(input real v);
    if (v >= 0.0) return $rtoi(v + 0.5);
    return -$rtoi(0.5 - v);
  endfunction

endpackage

// File: rtl/lowif_phase_ctrl.sv
module lowif_phase_ctrl #(
  parameter int PHW   = 4,
  parameter int OSRCW = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OSRCW-1:0] osr_sel,
  output logic [PHW-1:0]   phase,
  output logic [OSRCW-1:0] osr_q,
  output logic [1:0]       rot,
  output logic             boundary,
  output logic             sym_ready
);
  import lowif_pkg::*;

  function automatic logic [PHW-1:0] last_slot(input logic [OSRCW-1:0] code);
    return PHW'(osr_len(int'(code), PHW) - 1);
  endfunction

  logic [PHW-1:0]   phase_n;
  logic [OSRCW-1:0] osr_n;

  always_comb begin
    boundary = (phase == last_slot(osr_q));
    if (boundary) begin
      phase_n = '0;
      osr_n   = osr_sel;
    end else begin
      phase_n = phase + PHW'(1);
      osr_n   = osr_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= '0;
      osr_q     <= '0;
      rot       <= '0;
      sym_ready <= 1'b0;
    end else begin
      phase     <= phase_n;
      osr_q     <= osr_n;
      rot       <= rot + 2'd1;
      sym_ready <= (phase_n == last_slot(osr_n));
    end
  end
endmodule

// File: rtl/lowif_sym_hist.sv
module lowif_sym_hist #(
  parameter int TAPS = 4,
  parameter int IDXW = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        shift,
  input  logic                        sym_valid,
  input  logic [IDXW-1:0]             sym_i,
  input  logic [IDXW-1:0]             sym_q,
  output logic [TAPS-1:0][IDXW:0]     hist_i,
  output logic [TAPS-1:0][IDXW:0]     hist_q
);
  logic [IDXW:0] new_i, new_q;

  always_comb begin
    new_i = sym_valid ? {1'b1, sym_i} : '0;
    new_q = sym_valid ? {1'b1, sym_q} : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_i <= '0;
      hist_q <= '0;
    end else if (shift) begin
      hist_i <= {hist_i[TAPS-2:0], new_i};
      hist_q <= {hist_q[TAPS-2:0], new_q};
    end
  end
endmodule

// File: rtl/lowif_tap_rom.sv
module lowif_tap_rom #(
  parameter int  TAPS    = 4,
  parameter int  TAP     = 0,
  parameter int  IDXW    = 2,
  parameter int  PHW     = 4,
  parameter int  OSRCW   = 2,
  parameter int  SAMPW   = 12,
  parameter int  CSCALE  = 400,
  parameter real ROLLOFF = 0.4
) (
  input  logic                             clk,
  input  logic [OSRCW+IDXW+1+PHW-1:0]      addr,
  output logic [SAMPW-1:0]                 data
);
  import lowif_pkg::*;

  localparam int ADDRW = OSRCW + IDXW + 1 + PHW;
  localparam int DEPTH = 1 << ADDRW;

  logic [SAMPW-1:0] mem [DEPTH];

  initial begin
    int  rc, cd, ph, n, hq;
    real t;
    for (int a = 0; a < DEPTH; a++) begin
      rc = a >> (IDXW + 1 + PHW);
      cd = (a >> PHW) & ((1 << (IDXW + 1)) - 1);
      ph = a & ((1 << PHW) - 1);
      n  = osr_len(rc, PHW);
      if (ph >= n) begin
        mem[a] = '0;
      end else begin
        t  = real'(TAP) + real'(ph) / real'(n) - real'(TAPS) / 2.0;
        hq = round_int(rrc(t, ROLLOFF) / rrc(0.0, ROLLOFF) * real'(CSCALE));
        mem[a] = SAMPW'(sym_level(cd, IDXW) * hq);
      end
    end
  end

  always_ff @(posedge clk) begin
    data <= mem[addr];
  end
endmodule

// File: rtl/lowif_if_mixer.sv
module lowif_if_mixer #(
  parameter int TAPS  = 4,
  parameter int SAMPW = 12
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [TAPS-1:0][SAMPW-1:0]  tap_i,
  input  logic [TAPS-1:0][SAMPW-1:0]  tap_q,
  input  logic [1:0]                  rot,
  output logic [SAMPW-1:0]            samp_out,
  output logic                        samp_valid
);
  localparam int SUMW = SAMPW + $clog2(TAPS) + 1;

  logic [1:0]             rot_d;
  logic                   vld_d;
  logic signed [SUMW-1:0] sum_i, sum_q, sel;

  always_comb begin
    sum_i = '0;
    sum_q = '0;
    for (int k = 0; k < TAPS; k++) begin
      sum_i = sum_i + SUMW'($signed(tap_i[k]));
      sum_q = sum_q + SUMW'($signed(tap_q[k]));
    end
    case (rot_d)
      2'd0:    sel = sum_i;
      2'd1:    sel = sum_q;
      2'd2:    sel = -sum_i;
      default: sel = -sum_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rot_d      <= '0;
      vld_d      <= 1'b0;
      samp_out   <= '0;
      samp_valid <= 1'b0;
    end else begin
      rot_d      <= rot;
      vld_d      <= 1'b1;
      samp_out   <= sel[SAMPW-1:0];
      samp_valid <= vld_d;
    end
  end
endmodule

// File: rtl/lowif_modulator.sv
module lowif_modulator #(
  parameter int  TAPS    = 4,
  parameter int  IDXW    = 2,
  parameter int  SAMPW   = 12,
  parameter int  PHW     = 4,
  parameter int  OSRCW   = 2,
  parameter int  CSCALE  = 400,
  parameter real ROLLOFF = 0.4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OSRCW-1:0] osr_sel,
  input  logic             sym_valid,
  input  logic [IDXW-1:0]  sym_i,
  input  logic [IDXW-1:0]  sym_q,
  output logic             sym_ready,
  output logic             samp_valid,
  output logic [SAMPW-1:0] samp_out
);
  localparam int CODEW = IDXW + 1;

  logic [PHW-1:0]             phase;
  logic [OSRCW-1:0]           osr_q;
  logic [1:0]                 rot;
  logic                       boundary;
  logic [TAPS-1:0][CODEW-1:0] hist_i, hist_q;
  logic [TAPS-1:0][SAMPW-1:0] tap_i, tap_q;

  lowif_phase_ctrl #(.PHW(PHW), .OSRCW(OSRCW)) u_ctrl (
    .clk(clk), .rst(rst), .osr_sel(osr_sel), .phase(phase), .osr_q(osr_q),
    .rot(rot), .boundary(boundary), .sym_ready(sym_ready)
  );

  lowif_sym_hist #(.TAPS(TAPS), .IDXW(IDXW)) u_hist (
    .clk(clk), .rst(rst), .shift(boundary), .sym_valid(sym_valid),
    .sym_i(sym_i), .sym_q(sym_q), .hist_i(hist_i), .hist_q(hist_q)
  );

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    lowif_tap_rom #(.TAPS(TAPS), .TAP(k), .IDXW(IDXW), .PHW(PHW), .OSRCW(OSRCW),
                    .SAMPW(SAMPW), .CSCALE(CSCALE), .ROLLOFF(ROLLOFF)) u_rom_i (
      .clk(clk), .addr({osr_q, hist_i[k], phase}), .data(tap_i[k])
    );
    lowif_tap_rom #(.TAPS(TAPS), .TAP(k), .IDXW(IDXW), .PHW(PHW), .OSRCW(OSRCW),
                    .SAMPW(SAMPW), .CSCALE(CSCALE), .ROLLOFF(ROLLOFF)) u_rom_q (
      .clk(clk), .addr({osr_q, hist_q[k], phase}), .data(tap_q[k])
    );
  end

  lowif_if_mixer #(.TAPS(TAPS), .SAMPW(SAMPW)) u_mix (
    .clk(clk), .rst(rst), .tap_i(tap_i), .tap_q(tap_q), .rot(rot),
    .samp_out(samp_out), .samp_valid(samp_valid)
  );
endmodule

// File: rtl/lowif_modulator_chk.sv
module lowif_modulator_chk #(
  parameter int PHW   = 4,
  parameter int OSRCW = 2,
  parameter int SAMPW = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             sym_ready,
  input logic             samp_valid,
  input logic [SAMPW-1:0] samp_out,
  input logic [PHW-1:0]   phase,
  input logic [OSRCW-1:0] osr_code
);
  logic [5:0] gap;
  logic       seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (sym_ready) begin
      gap  <= 6'd1;
      seen <= 1'b1;
    end else if (gap != 6'h3f) begin
      gap  <= gap + 6'd1;
    end
  end

  // R1: first cycle after reset still quiet
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!samp_valid && !sym_ready && samp_out == '0));

  // R2: once valid, stays valid
  p_valid_hold_r2: assert property (@(posedge clk) disable iff (rst)
    samp_valid |=> samp_valid);

  // R3: ready spacing is one legal symbol length
  p_ready_gap_r3: assert property (@(posedge clk) disable iff (rst)
    (sym_ready && seen) |-> (gap == 6'd4 || gap == 6'd8 || gap == 6'd16));

  // R3: ready only in the last slot of the symbol
  p_ready_slot_r3: assert property (@(posedge clk) disable iff (rst)
    sym_ready |-> (int'(phase) == lowif_pkg::osr_len(int'(osr_code), PHW) - 1));

  // R8: rate code moves only at a symbol boundary
  p_rate_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !sym_ready |=> $stable(osr_code));

  // R9: phase stays inside the current symbol length
  p_phase_bound_r9: assert property (@(posedge clk) disable iff (rst)
    int'(phase) < lowif_pkg::osr_len(int'(osr_code), PHW));
endmodule

bind lowif_modulator lowif_modulator_chk #(.PHW(PHW), .OSRCW(OSRCW), .SAMPW(SAMPW)) u_chk (
  .clk(clk), .rst(rst), .sym_ready(sym_ready), .samp_valid(samp_valid),
  .samp_out(samp_out), .phase(phase), .osr_code(osr_q)
);

// File: tb/lowif_modulator_tb.sv
module lowif_modulator_tb;
  localparam int TAPS = 4;
  localparam int CSCALE = 400;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  osr_sel = '0;
  logic        sym_valid = 1'b0;
  logic [1:0]  sym_i = '0, sym_q = '0;
  logic        sym_ready, samp_valid;
  logic [11:0] samp_out;

  always #4 clk = ~clk;

  lowif_modulator u_dut (
    .clk(clk), .rst(rst), .osr_sel(osr_sel), .sym_valid(sym_valid),
    .sym_i(sym_i), .sym_q(sym_q), .sym_ready(sym_ready),
    .samp_valid(samp_valid), .samp_out(samp_out)
  );

  typedef struct {
    bit    learn;
    int    exp;
    int    oi, k, p, sgn;
    string req;
  } item_t;

  item_t sbq[$];
  int    h[3][TAPS][16];
  int    errors = 0, checks = 0, cyc = 0;
  bit    done = 0, learn_on = 0;
  string cur_req = "R2";

  int         m_ph = 0, m_rot = 0, m_osr = 0;
  logic [2:0] m_hi [TAPS];
  logic [2:0] m_hq [TAPS];

  function automatic int osr_n(int code);
    return (code == 0) ? 4 : (code == 1) ? 8 : 16;
  endfunction
  function automatic int oidx(int code);
    return (code > 2) ? 2 : code;
  endfunction
  function automatic int lvl(logic [2:0] c);
    return c[2] ? 2 * int'(c[1:0]) - 3 : 0;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic monitor_cycle();
    item_t it;
    if (cyc >= 2) check(samp_valid == 1'b1, "R2 valid", int'(samp_valid), 1);
    if (samp_valid) begin
      if (sbq.size() == 0) check(1'b0, "R2 latency", 0, 1);
      else begin
        it = sbq.pop_front();
        if (it.learn) h[it.oi][it.k][it.p] = int'($signed(samp_out)) * it.sgn;
        else check(int'($signed(samp_out)) == it.exp, it.req, int'($signed(samp_out)), it.exp);
      end
    end
  endtask

  task automatic drive_cycle(bit offer, int ii, int qi, int osr_in);
    item_t it;
    int nz, kimp, ai, aq, oi, last;
    monitor_cycle();
    oi = oidx(m_osr);
    last = osr_n(m_osr) - 1;
    nz = 0; kimp = 0; ai = 0; aq = 0;
    for (int k = 0; k < TAPS; k++) begin
      if (m_hi[k] != 0 || m_hq[k] != 0) begin nz++; kimp = k; end
      ai += lvl(m_hi[k]) * h[oi][k][m_ph];
      aq += lvl(m_hq[k]) * h[oi][k][m_ph];
    end
    it.req = cur_req; it.oi = oi; it.k = kimp; it.p = m_ph;
    it.sgn = (m_rot >= 2) ? -1 : 1;
    it.learn = learn_on && nz == 1 && m_hi[kimp] == 3'b110 && m_hq[kimp] == 3'b110;
    case (m_rot)
      0: it.exp = ai;
      1: it.exp = aq;
      2: it.exp = -ai;
      default: it.exp = -aq;
    endcase
    sbq.push_back(it);
    check(sym_ready == (m_ph == last), "R3 ready slot", int'(sym_ready), int'(m_ph == last));
    osr_sel = osr_in[1:0]; sym_valid = offer; sym_i = ii[1:0]; sym_q = qi[1:0];
    if (m_ph == last) begin
      for (int k = TAPS - 1; k > 0; k--) begin m_hi[k] = m_hi[k-1]; m_hq[k] = m_hq[k-1]; end
      m_hi[0] = offer ? {1'b1, ii[1:0]} : 3'b000;
      m_hq[0] = offer ? {1'b1, qi[1:0]} : 3'b000;
      m_osr = osr_in; m_ph = 0;
    end else m_ph++;
    m_rot = (m_rot + 1) % 4;
    @(posedge clk); @(negedge clk);
    cyc++;
  endtask

  task automatic run_symbol(bit offer, int ii, int qi, int code, bit noisy);
    bit last;
    do begin
      last = (m_ph == osr_n(m_osr) - 1);
      if (last) drive_cycle(offer, ii, qi, code);
      else if (noisy) drive_cycle(bit'($urandom % 2), $urandom % 4, $urandom % 4, $urandom % 4);
      else drive_cycle(1'b0, 0, 0, code);
    end while (!last);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    for (int k = 0; k < TAPS; k++) begin m_hi[k] = '0; m_hq[k] = '0; end
    // R1: reset state, inputs toggling are ignored
    sym_valid = 1'b1; sym_i = 2'd3; osr_sel = 2'd2;
    repeat (3) @(negedge clk);
    check(samp_valid == 1'b0, "R1 valid", int'(samp_valid), 0);
    check(sym_ready == 1'b0, "R1 ready", int'(sym_ready), 0);
    check(samp_out == '0, "R1 sample", int'($signed(samp_out)), 0);
    rst = 1'b0; sym_valid = 1'b0; osr_sel = '0;
    check(samp_out == '0 && !samp_valid, "R1 release", int'(samp_valid), 0);

    for (int o = 0; o < 3; o++) begin
      cur_req = "R4 idle fill";
      for (int s = 0; s < 6; s++) run_symbol(1'b0, 0, 0, o, 1'b0);
      learn_on = 1; cur_req = "R7";
      run_symbol(1'b1, 2, 2, o, 1'b0);
      for (int s = 0; s < 5; s++) run_symbol(1'b0, 0, 0, o, 1'b0);
      learn_on = 0;
      n = osr_n(o);
      check(h[o][2][0] == CSCALE, "R7 peak tap", h[o][2][0], CSCALE);
      for (int q = 1; q < n; q++)
        check(h[o][1][q] == h[o][2][n-q], "R7 symmetry", h[o][1][q], h[o][2][n-q]);
      for (int k = 0; k < TAPS; k++)
        for (int p = 0; p < n; p++)
          if (h[o][k][p] > CSCALE || h[o][k][p] < -CSCALE)
            check(1'b0, "R7 peak bound", h[o][k][p], CSCALE);
      for (int p = 1; p < 4; p++)
        check(h[o][2][p] > 0, "R5 rotation sign", h[o][2][p], 1);
      cur_req = "R6 R3 random symbols";
      for (int s = 0; s < 25; s++)
        run_symbol(($urandom % 100) < 85, $urandom % 4, $urandom % 4, o, 1'b1);
      cur_req = "R4 idle after data";
      for (int s = 0; s < 3; s++) run_symbol(1'b0, 0, 0, o, 1'b1);
    end

    cur_req = "R8 R9 rate switch";
    for (int s = 0; s < 40; s++)
      run_symbol(($urandom % 100) < 90, $urandom % 4, $urandom % 4, $urandom % 4, 1'b1);
    cur_req = "R6 extremes";
    for (int s = 0; s < 6; s++)
      run_symbol(1'b1, (s % 2) ? 3 : 0, (s % 2) ? 0 : 3, 0, 1'b0);
    for (int s = 0; s < 5; s++) run_symbol(1'b0, 0, 0, 1, 1'b0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule